// File: doc/BRIEF.md
# Absolute-Mode Physical Address Mapper

This block turns an absolute address into a physical address when virtual translation is switched off. It takes a 64-bit absolute address, a wide/narrow mode select and a flag that marks the older architecture level. It returns the physical address together with a 2-bit region tag and a read/write/execute grant, one clock after the request.

Wide mode keeps the implemented physical width and sign-extends from its top bit. Narrow mode on the newer level only looks at the low 32 bits. It splits the highest sixteenth of that 32-bit space into an I/O window, which is sign-extended, and a firmware window, which is moved to the top of the physical space. Everything else in narrow mode is ordinary memory and is zero-extended. On the older level, narrow mode always zero-extends the low 32 bits. The implemented physical width `PA_W` is a parameter between 29 and 54 bits.

Top module: `abs_phys_mapper`

## Requirements
- R1: With `in_wide`=1, the result is `in_addr[PA_W-1:0]` sign-extended from bit `PA_W-1` to 64 bits, whatever `in_legacy` is, and the region tag is 3.
- R2: With `in_wide`=0, `in_legacy`=0 and `in_addr[31:28]` not equal to 4'hF, the result is `in_addr[31:0]` zero-extended, and the region tag is 0 (memory).
- R3: With `in_wide`=0, `in_legacy`=0, `in_addr[31:28]`=4'hF and `in_addr[27:24]` nonzero, the result is `in_addr[31:0]` sign-extended from bit 31, and the region tag is 1 (I/O).
- R4: With `in_wide`=0, `in_legacy`=0 and `in_addr[31:24]`=8'hF0, the result keeps `in_addr[23:0]`, sets bits 63 down to `PA_W-4` to one and clears bits `PA_W-5` down to 24, and the region tag is 2 (firmware).
- R5: With `in_wide`=0 and `in_legacy`=1, the result is `in_addr[31:0]` zero-extended for every value of the top nibble, and the region tag is 0.
- R6: `out_valid` is 0 during reset and in the first cycle after it, and is high exactly one clock after each cycle in which `in_valid` was high.
- R7: `out_perm` (bit 2 read, bit 1 write, bit 0 execute) is 3'b111 whenever `out_valid` is 1 and 3'b000 otherwise.
- R8: In a cycle with `in_valid`=0, `out_paddr` and `out_region` keep the values of the last accepted request (zero after reset), whatever the other inputs do.
- R9: In narrow mode, `in_addr[63:32]` has no effect on the result or on the region tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 64 | Absolute address |
| in_wide | input | 1 | 1 = wide absolute mode, 0 = narrow |
| in_legacy | input | 1 | 1 = older architecture level (narrow mode only) |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_paddr | output | 64 | Physical address |
| out_region | output | 2 | 0 memory, 1 I/O, 2 firmware, 3 wide |
| out_perm | output | 3 | Granted rights {read, write, execute} |

## Verification
The hardest cases sit on the boundaries between narrow windows. 0xF0000000 and 0xF0FFFFFF are firmware, while 0xF1000000 and 0xEFFFFFFF fall into the neighbouring windows. Random addresses almost never land on these, so the stimulus places them directly. It also biases the random top byte toward 0xF0 and 0xF-, with junk in the upper 32 bits, and repeats the same addresses with the legacy flag and wide mode set. Hold behaviour is exercised by idle cycles in which every other input changes.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned NARROW_W = 32;

  typedef enum logic [1:0] {
    RGN_MEM  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_FW   = 2'd2,
    RGN_WIDE = 2'd3
  } apm_region_e;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/apm_rst_sync.sv
module apm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/apm_classify.sv
module apm_classify
  import apm_pkg::*;
(
  input  logic [7:0]  top_byte,
  input  logic        wide,
  input  logic        legacy,
  output apm_region_e region
);
  logic hi_nib_ones;
  logic sub_nib_zero;

  always_comb begin
    hi_nib_ones  = (top_byte[7:4] == 4'hF);
    sub_nib_zero = (top_byte[3:0] == 4'h0);
    if (wide)              region = RGN_WIDE;
    else if (legacy)       region = RGN_MEM;
    else if (!hi_nib_ones) region = RGN_MEM;
    else if (!sub_nib_zero) region = RGN_IO;
    else                   region = RGN_FW;
  end
endmodule

// File: rtl/apm_extend.sv
module apm_extend
  import apm_pkg::*;
#(
  parameter int unsigned PA_W = 40
) (
  input  logic [ADDR_W-1:0] addr,
  input  apm_region_e       region,
  output logic [ADDR_W-1:0] paddr
);
  localparam int unsigned FW_LSB  = PA_W - 4;
  localparam int unsigned WIDE_HI = ADDR_W - PA_W;
  localparam int unsigned FW_ONES = ADDR_W - FW_LSB;
  localparam int unsigned FW_GAP  = FW_LSB - 24;

  logic [ADDR_W-1:0] wide_ext;
  logic [ADDR_W-1:0] mem_ext;
  logic [ADDR_W-1:0] io_ext;
  logic [ADDR_W-1:0] fw_ext;

  always_comb begin
    wide_ext = {{WIDE_HI{addr[PA_W-1]}}, addr[PA_W-1:0]};
    mem_ext  = {{(ADDR_W-NARROW_W){1'b0}}, addr[NARROW_W-1:0]};
    io_ext   = {{(ADDR_W-NARROW_W){addr[NARROW_W-1]}}, addr[NARROW_W-1:0]};
    fw_ext   = {{FW_ONES{1'b1}}, {FW_GAP{1'b0}}, addr[23:0]};
    unique case (region)
      RGN_WIDE: paddr = wide_ext;
      RGN_IO:   paddr = io_ext;
      RGN_FW:   paddr = fw_ext;
      default:  paddr = mem_ext;
    endcase
  end
endmodule

// File: rtl/abs_phys_mapper.sv
module abs_phys_mapper
  import apm_pkg::*;
#(
  parameter int unsigned PA_W = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_addr,
  input  logic        in_wide,
  input  logic        in_legacy,
  output logic        out_valid,
  output logic [63:0] out_paddr,
  output logic [1:0]  out_region,
  output logic [2:0]  out_perm
);
  localparam int unsigned FW_LSB = PA_W - 4;

  generate
    if (PA_W > 54 || PA_W < 29) begin : g_bad_width
      $error("abs_phys_mapper: PA_W must lie in 29..54");
    end
  endgenerate

  logic              rst_q;
  apm_region_e       region_d;
  logic [ADDR_W-1:0] paddr_d;

  logic              valid_q,  valid_d;
  logic [ADDR_W-1:0] paddr_q,  paddr_n;
  logic [1:0]        region_q, region_n;
  logic [2:0]        perm_q,   perm_d;
  logic              cap_en;

  apm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  apm_classify u_classify (
    .top_byte (in_addr[31:24]),
    .wide     (in_wide),
    .legacy   (in_legacy),
    .region   (region_d)
  );

  apm_extend #(.PA_W(PA_W)) u_extend (
    .addr   (in_addr),
    .region (region_d),
    .paddr  (paddr_d)
  );

  always_comb begin
    cap_en   = in_valid;
    valid_d  = in_valid;
    perm_d   = in_valid ? PERM_ALL : PERM_NONE;
    paddr_n  = cap_en ? paddr_d : paddr_q;
    region_n = cap_en ? region_d : region_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      valid_q  <= 1'b0;
      perm_q   <= PERM_NONE;
      paddr_q  <= '0;
      region_q <= RGN_MEM;
    end else begin
      valid_q  <= valid_d;
      perm_q   <= perm_d;
      paddr_q  <= paddr_n;
      region_q <= region_n;
    end
  end

  assign out_valid  = valid_q;
  assign out_paddr  = paddr_q;
  assign out_region = region_q;
  assign out_perm   = perm_q;

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);
  p_perm_on_r7: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> out_perm == PERM_ALL);
  p_perm_off_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !out_valid |-> out_perm == PERM_NONE);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ($stable(out_paddr) && $stable(out_region)));
  p_mem_zero_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_region == RGN_MEM) |-> out_paddr[63:32] == 32'h0);
  p_io_sign_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_region == RGN_IO) |-> (&out_paddr[63:31]));
  p_fw_place_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_region == RGN_FW) |->
      ((&out_paddr[63:FW_LSB]) && out_paddr[FW_LSB-1:24] == '0));
  p_wide_sign_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_region == RGN_WIDE) |->
      ((&out_paddr[63:PA_W-1]) || !(|out_paddr[63:PA_W-1])));
  p_legacy_mem_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !in_wide && in_legacy) |=> out_region == RGN_MEM);
  p_wide_tag_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_wide) |=> out_region == RGN_WIDE);
endmodule

// File: tb/abs_phys_mapper_bench.sv
module abs_phys_mapper_bench;
  localparam int PA = 40;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_addr;
  logic        in_wide;
  logic        in_legacy;
  logic        out_valid;
  logic [63:0] out_paddr;
  logic [1:0]  out_region;
  logic [2:0]  out_perm;

  int total;
  int bad;
  bit done;

  logic        e_valid;
  logic [63:0] e_paddr;
  logic [1:0]  e_region;

  abs_phys_mapper #(.PA_W(PA)) u_abs_phys_mapper (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .in_wide    (in_wide),
    .in_legacy  (in_legacy),
    .out_valid  (out_valid),
    .out_paddr  (out_paddr),
    .out_region (out_region),
    .out_perm   (out_perm)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic void ref_map(input logic [63:0] a, input bit w, input bit l,
                                  output logic [63:0] p, output logic [1:0] r);
    logic [63:0] m;
    logic [63:0] lo32;
    m    = (64'd1 << PA) - 64'd1;
    lo32 = 64'h0000_0000_FFFF_FFFF;
    if (w) begin
      p = a[PA-1] ? (a | ~m) : (a & m);
      r = 2'd3;
    end else if (l) begin
      p = a & lo32;
      r = 2'd0;
    end else if (a[31:28] != 4'hF) begin
      p = a & lo32;
      r = 2'd0;
    end else if (a[27:24] != 4'h0) begin
      p = (a & lo32) | ~lo32;
      r = 2'd1;
    end else begin
      p = (a & 64'h0000_0000_00FF_FFFF) | (~64'd0 << (PA - 4));
      r = 2'd2;
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] a, input bit w,
                      input bit l, input string tag);
    logic [63:0] p;
    logic [1:0]  r;
    in_valid  = v;
    in_addr   = a;
    in_wide   = w;
    in_legacy = l;
    @(posedge clk);
    @(negedge clk);
    ref_map(a, w, l, p, r);
    e_valid = v;
    if (v) begin
      e_paddr  = p;
      e_region = r;
    end
    check(out_valid === e_valid, "R6", "out_valid", 64'(out_valid), 64'(e_valid));
    check(out_perm === (e_valid ? 3'b111 : 3'b000), "R7", "out_perm",
          64'(out_perm), 64'(e_valid ? 3'b111 : 3'b000));
    check(out_paddr === e_paddr, v ? tag : "R8", "out_paddr", out_paddr, e_paddr);
    check(out_region === e_region, v ? tag : "R8", "out_region",
          64'(out_region), 64'(e_region));
  endtask

  function automatic string tag_of(input logic [63:0] a, input bit w, input bit l);
    logic [63:0] p;
    logic [1:0]  r;
    ref_map(a, w, l, p, r);
    if (w) return "R1";
    if (l) return "R5";
    case (r)
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(150000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    e_valid = 0; e_paddr = '0; e_region = 2'd0;
    rst_n = 0; in_valid = 0; in_addr = '0; in_wide = 0; in_legacy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R6", "reset out_valid", 64'(out_valid), 64'd0);
    check(out_perm === 3'b000, "R7", "reset out_perm", 64'(out_perm), 64'd0);
    check(out_paddr === 64'd0, "R8", "reset out_paddr", out_paddr, 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R6", "post-reset out_valid", 64'(out_valid), 64'd0);

    // R1: wide mode, both signs, legacy flag ignored
    step(1, 64'h0000_0012_3456_789A, 1, 0, "R1");
    step(1, 64'h0000_0080_0000_0001, 1, 0, "R1");
    step(1, 64'hABCD_00FF_FFFF_FFFF, 1, 1, "R1");
    step(1, 64'h1234_007F_FFFF_FFFF, 1, 0, "R1");
    // R2 / R9: narrow memory, upper junk ignored, window boundary
    step(1, 64'h0000_0000_1234_5678, 0, 0, "R2");
    step(1, 64'hDEAD_BEEF_1234_5678, 0, 0, "R9");
    step(1, 64'h0000_0000_EFFF_FFFF, 0, 0, "R2");
    // R3: I/O window edges
    step(1, 64'h0000_0000_F100_0000, 0, 0, "R3");
    step(1, 64'h5555_5555_FFFF_FFFF, 0, 0, "R9");
    // R4: firmware window edges
    step(1, 64'h0000_0000_F000_0000, 0, 0, "R4");
    step(1, 64'h0000_0000_F0FF_FFFF, 0, 0, "R4");
    step(1, 64'hFFFF_FFFF_F0AB_CDEF, 0, 0, "R9");
    // R5: legacy narrow zero-extends every window
    step(1, 64'h0000_0000_F0AB_CDEF, 0, 1, "R5");
    step(1, 64'h7777_0000_FF00_0000, 0, 1, "R5");
    // R8: idle cycles with changing inputs
    step(0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R8");
    step(0, 64'h0000_0000_F000_0001, 0, 0, "R8");
    step(1, 64'h0000_0000_F012_3456, 0, 0, "R4");
    step(0, 64'h0000_0000_0000_0000, 0, 1, "R8");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      bit v, w, l;
      int sel;
      a   = {$urandom, $urandom};
      sel = $urandom_range(0, 3);
      if (sel == 1) a[31:24] = 8'hF0;
      if (sel == 2) a[31:28] = 4'hF;
      v = ($urandom_range(0, 3) != 0);
      w = ($urandom_range(0, 3) == 0);
      l = ($urandom_range(0, 3) == 0);
      step(v, a, w, l, tag_of(a, w, l));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule